// File: doc/BRIEF.md
# Pin-Change Detector and Interrupt Combiner

This block gathers the interrupt requests of two serial channels (called A and B) and adds a small monitor for four general-purpose input pins. Each pin passes through a clock-domain synchronizer. When a pin has detection switched on, any edge on it sets a sticky change flag. The flags of the pins that belong to a channel are merged into that channel's "input" interrupt source. Software sees the live pin levels and the sticky flags in one change register, and reading that register clears the flags.

For each channel, four sources are collected into one status nibble: transmit, receive, break and input. The two nibbles share one combined status byte, and a combined mask byte gates it. Each channel also has its own status and mask view, which holds only its nibble. The per-channel mask view and the combined mask share the same storage. The block drives one level-sensitive interrupt line per channel and a line that is the OR of the two. The serial channels sit outside the block and reach it as plain request bits.

Top module: `pinchg_irq_hub`

## Requirements
- R1: After reset, the change register, the enable register, the mask and all interrupt outputs are zero, with the pins held low.
- R2: Change register (address 0) bits [3:0] show the synchronized level of pins 0–3. A pin change applied between two clock edges shows up after the second following rising edge and not after the first.
- R3: Any edge, rising or falling, on a pin whose enable bit is 1 sets that pin's change flag at bit 4+i of the change register, three rising edges after the pin moves. An edge on a pin whose enable bit is 0 sets nothing.
- R4: A read of address 0 returns the flags as they were and then clears them. If a new enabled edge lands in the same cycle as the read, that flag stays set.
- R5: The enable register (address 1) keeps bits [3:0] and reads zero in bits [7:4]. Bit i enables detection on pin i.
- R6: Combined status (address 2) bit 4c+0 is channel c's transmit request, bit 4c+1 its receive request, bit 4c+2 its break request, and bit 4c+3 its input source. Channel A is c=0 and channel B is c=1. The input source is the OR of (flag AND enable) over pins 0–1 for A and over pins 2–3 for B.
- R7: The combined mask (address 3) can be written and read back. It uses the same bit layout as the combined status, and a 1 lets a source through.
- R8: The per-channel status views are at address 4 for A and 6 for B. Each returns its channel's nibble in bits [3:0] and zero in bits [7:4].
- R9: The per-channel mask views are at address 5 for A and 7 for B. They alias the matching nibble of the combined mask. A write to either view changes the other, and bits [7:4] of a per-channel write are ignored.
- R10: `irq_chan[c]` is the OR over channel c's nibble of (status AND mask). `irq_any` is the OR of both channel lines.
- R11: Writes to the read-only addresses 0, 2, 4 and 6 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | NUM_PINS | General input pins, not synchronized |
| uart_tx_req | input | NUM_CH | Transmit request per channel |
| uart_rx_req | input | NUM_CH | Receive request per channel |
| uart_brk_req | input | NUM_CH | Break request per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reading address 0 clears the flags |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from the address |
| irq_chan | output | NUM_CH | Per-channel interrupt line, index 0 is channel A |
| irq_any | output | 1 | OR of all channel lines |

## Verification
The hardest case to reach is a clearing read that falls in exactly the cycle in which a synchronized edge reaches a flag. In that cycle one flag must drop and another must survive. The stimulus first leaves pin 1's flag set. It then raises pin 2 and issues the read of the change register two falling edges later, so the read's rising edge is the third after the pin change. A later peek at the register, with the read strobe low, must show pin 1's flag cleared and pin 2's flag set. The aliasing of the mask views is reached by writing the combined byte and each nibble view in turn, and checking both the read-back and the interrupt lines.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
   // source order inside a channel nibble
   localparam int SRC_PER_CH = 4;
   localparam int SRC_TX     = 0;
   localparam int SRC_RX     = 1;
   localparam int SRC_BRK    = 2;
   localparam int SRC_INP    = 3;

   // register offsets; channel views follow at BASE + 2*c (status), +1 (mask)
   localparam int OFS_CHG     = 0;
   localparam int OFS_AUX     = 1;
   localparam int OFS_ISR     = 2;
   localparam int OFS_IMR     = 3;
   localparam int OFS_CH_BASE = 4;
endpackage

// File: rtl/chg_detect.sv
module chg_detect #(
   parameter int NUM_PINS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_async,
   input  logic [NUM_PINS-1:0] en,
   input  logic                clr,
   output logic [NUM_PINS-1:0] level,
   output logic [NUM_PINS-1:0] flags,
   output logic [NUM_PINS-1:0] edge_hit
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("chg_detect: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [SYNC_STAGES-1:0] sh;
      logic                   prev;
      logic                   flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh     <= '0;
            prev   <= 1'b0;
            flag_q <= 1'b0;
         end else begin
            sh     <= {sh[SYNC_STAGES-2:0], pin_async[i]};
            prev   <= sh[SYNC_STAGES-1];
            // a new edge wins over a clearing read in the same cycle
            flag_q <= (flag_q & ~clr) | (edge_hit[i] & en[i]);
         end
      end

      assign level[i]    = sh[SYNC_STAGES-1];
      assign edge_hit[i] = sh[SYNC_STAGES-1] ^ prev;
      assign flags[i]    = flag_q;
   end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
   import irqhub_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int NUM_CH   = 2,
   localparam int PPC     = NUM_PINS / NUM_CH,
   localparam int MW      = NUM_CH * SRC_PER_CH
) (
   input  logic [NUM_CH-1:0]   tx_req,
   input  logic [NUM_CH-1:0]   rx_req,
   input  logic [NUM_CH-1:0]   brk_req,
   input  logic [NUM_PINS-1:0] flags,
   input  logic [NUM_PINS-1:0] en,
   input  logic [MW-1:0]       mask,
   output logic [MW-1:0]       status,
   output logic [NUM_CH-1:0]   irq_chan
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic inp;
      assign inp = |(flags[c*PPC +: PPC] & en[c*PPC +: PPC]);

      assign status[c*SRC_PER_CH + SRC_TX]  = tx_req[c];
      assign status[c*SRC_PER_CH + SRC_RX]  = rx_req[c];
      assign status[c*SRC_PER_CH + SRC_BRK] = brk_req[c];
      assign status[c*SRC_PER_CH + SRC_INP] = inp;

      assign irq_chan[c] = |(status[c*SRC_PER_CH +: SRC_PER_CH] &
                             mask[c*SRC_PER_CH +: SRC_PER_CH]);
   end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irqhub_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int NUM_CH   = 2,
   parameter int DW       = 8,
   parameter int AW       = 3,
   localparam int MW      = NUM_CH * SRC_PER_CH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       wdata,
   input  logic [NUM_PINS-1:0] level,
   input  logic [NUM_PINS-1:0] flags,
   input  logic [MW-1:0]       status,
   output logic [DW-1:0]       rdata,
   output logic [NUM_PINS-1:0] aux_en,
   output logic [MW-1:0]       mask,
   output logic                chg_clr
);
   logic [MW-1:0] mask_d;

   assign chg_clr = rd && (addr == AW'(OFS_CHG));

   always_comb begin
      mask_d = mask;
      if (wr) begin
         if (addr == AW'(OFS_IMR)) mask_d = wdata[MW-1:0];
         for (int c = 0; c < NUM_CH; c++) begin
            if (addr == AW'(OFS_CH_BASE + 2*c + 1))
               mask_d[c*SRC_PER_CH +: SRC_PER_CH] = wdata[SRC_PER_CH-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_en <= '0;
         mask   <= '0;
      end else begin
         if (wr && addr == AW'(OFS_AUX)) aux_en <= wdata[NUM_PINS-1:0];
         mask <= mask_d;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(OFS_CHG)) rdata[2*NUM_PINS-1:0] = {flags, level};
      if (addr == AW'(OFS_AUX)) rdata[NUM_PINS-1:0]   = aux_en;
      if (addr == AW'(OFS_ISR)) rdata[MW-1:0]         = status;
      if (addr == AW'(OFS_IMR)) rdata[MW-1:0]         = mask;
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == AW'(OFS_CH_BASE + 2*c))
            rdata[SRC_PER_CH-1:0] = status[c*SRC_PER_CH +: SRC_PER_CH];
         if (addr == AW'(OFS_CH_BASE + 2*c + 1))
            rdata[SRC_PER_CH-1:0] = mask[c*SRC_PER_CH +: SRC_PER_CH];
      end
   end
endmodule

// File: rtl/pinchg_irq_hub.sv
module pinchg_irq_hub
   import irqhub_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int NUM_CH      = 2,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(OFS_CH_BASE + 2*NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_async,
   input  logic [NUM_CH-1:0]   uart_tx_req,
   input  logic [NUM_CH-1:0]   uart_rx_req,
   input  logic [NUM_CH-1:0]   uart_brk_req,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [AW-1:0]       reg_addr,
   input  logic [DW-1:0]       reg_wdata,
   output logic [DW-1:0]       reg_rdata,
   output logic [NUM_CH-1:0]   irq_chan,
   output logic                irq_any
);
   localparam int MW = NUM_CH * SRC_PER_CH;

   if (NUM_PINS % NUM_CH != 0) begin : g_bad_split
      $error("pinchg_irq_hub: pins must split evenly over channels");
   end
   if (DW < 2*NUM_PINS || DW < MW) begin : g_bad_dw
      $error("pinchg_irq_hub: DW too narrow for packed registers");
   end

   logic [NUM_PINS-1:0] level, chg_flags, edge_hit, aux_en;
   logic [MW-1:0]       status, mask_q;
   logic                chg_clr;

   chg_detect #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .en(aux_en),
      .clr(chg_clr), .level(level), .flags(chg_flags), .edge_hit(edge_hit)
   );

   irq_merge #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_merge (
      .tx_req(uart_tx_req), .rx_req(uart_rx_req), .brk_req(uart_brk_req),
      .flags(chg_flags), .en(aux_en), .mask(mask_q),
      .status(status), .irq_chan(irq_chan)
   );

   irq_regs #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .level(level), .flags(chg_flags), .status(status),
      .rdata(reg_rdata), .aux_en(aux_en), .mask(mask_q), .chg_clr(chg_clr)
   );

   assign irq_any = |irq_chan;
endmodule

// File: rtl/irqhub_chk.sv
module irqhub_chk #(
   parameter int NUM_PINS = 4,
   parameter int NUM_CH   = 2,
   parameter int MW       = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                chg_clr,
   input logic [NUM_PINS-1:0] chg_flags,
   input logic [NUM_PINS-1:0] edge_hit,
   input logic [NUM_PINS-1:0] aux_en,
   input logic [MW-1:0]       mask_q,
   input logic [NUM_CH-1:0]   uart_tx_req,
   input logic [NUM_CH-1:0]   irq_chan,
   input logic                irq_any
);
   // R3: flags never drop without a clearing read
   p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_clr |=> ((chg_flags & $past(chg_flags)) == $past(chg_flags)));

   // R3: no new flag while every pin is disabled
   p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_en == '0) |=> ((chg_flags & ~$past(chg_flags)) == '0));

   // R4: a read with no edge in flight leaves no flag behind
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_clr && edge_hit == '0) |=> (chg_flags == '0));

   // R10: unmasked transmit request of channel A raises its line
   p_tx_reaches_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[0] && uart_tx_req[0]) |-> irq_chan[0]);

   // R10: an all-zero mask keeps every line quiet
   p_mask_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> (!irq_any && irq_chan == '0));
endmodule

bind pinchg_irq_hub irqhub_chk #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH), .MW(MW)) u_chk (
   .clk(clk), .rst_n(rst_n), .chg_clr(chg_clr), .chg_flags(chg_flags),
   .edge_hit(edge_hit), .aux_en(aux_en), .mask_q(mask_q),
   .uart_tx_req(uart_tx_req), .irq_chan(irq_chan), .irq_any(irq_any)
);

// File: tb/tb_pinchg_irq_hub.sv
module tb_pinchg_irq_hub;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pin_async = '0;
   logic [1:0] uart_tx_req = '0, uart_rx_req = '0, uart_brk_req = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] irq_chan;
   logic       irq_any;

   int nvec = 0;
   int nbad = 0;
   logic [7:0] d;

   always #5 clk = ~clk;

   pinchg_irq_hub dut (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
      .uart_tx_req(uart_tx_req), .uart_rx_req(uart_rx_req), .uart_brk_req(uart_brk_req),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_chan(irq_chan), .irq_any(irq_any)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // combinational view of a register without a read strobe
   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 8; a++) begin
         peek(3'(a), d);
         chk("R1 reset register", d, 8'h00);
      end
      chk("R1 reset irq", {5'b0, irq_any, irq_chan}, 8'h00);
   endtask

   task automatic t_aux;
      wr(3'd1, 8'hFF);
      rd(3'd1, d);
      chk("R5 aux reserved bits", d, 8'h0F);
      wr(3'd1, 8'h00);
   endtask

   task automatic t_live;
      @(negedge clk); pin_async = 4'b0101;
      @(negedge clk); peek(3'd0, d);
      chk("R2 level after one edge", d, 8'h00);
      @(negedge clk); peek(3'd0, d);
      chk("R2 level after two edges", d, 8'h05);
      settle(2); peek(3'd0, d);
      chk("R3 disabled pins set no flag", d, 8'h05);
      @(negedge clk); pin_async = 4'b0000;
      settle(4); peek(3'd0, d);
      chk("R3 disabled falling edges", d, 8'h00);
   endtask

   task automatic t_flag;
      wr(3'd1, 8'h0F);
      @(negedge clk); pin_async = 4'b0010;
      settle(2); peek(3'd0, d);
      chk("R3 flag not yet set", d, 8'h02);
      @(negedge clk); peek(3'd0, d);
      chk("R3 flag set on rise", d, 8'h22);
      peek(3'd2, d);
      chk("R6 channel A input bit3", d, 8'h08);
      rd(3'd0, d);
      chk("R4 read returns flag", d, 8'h22);
      peek(3'd0, d);
      chk("R4 read cleared flag", d, 8'h02);
      @(negedge clk); pin_async = 4'b0000;
      settle(4); peek(3'd0, d);
      chk("R3 flag set on fall", d, 8'h20);
   endtask

   task automatic t_race;
      // pin1 flag still set; read lands on pin2's flag-setting edge
      @(negedge clk); pin_async = 4'b0100;
      @(negedge clk);
      rd(3'd0, d);
      chk("R4 race read value", d, 8'h24);
      peek(3'd0, d);
      chk("R4 edge wins over clear", d, 8'h44);
      rd(3'd0, d);
      @(negedge clk); pin_async = 4'b0000;
      settle(4);
      rd(3'd0, d);
      peek(3'd0, d);
      chk("R4 all flags clear", d, 8'h00);
   endtask

   task automatic t_merge;
      uart_tx_req = 2'b01; uart_rx_req = 2'b10; uart_brk_req = 2'b00;
      @(negedge clk); pin_async = 4'b1000;
      settle(4);
      peek(3'd2, d);
      chk("R6 combined status", d, 8'hA1);
      peek(3'd4, d);
      chk("R8 channel A status", d, 8'h01);
      peek(3'd6, d);
      chk("R8 channel B status", d, 8'h0A);
      chk("R10 masked off", {5'b0, irq_any, irq_chan}, 8'h00);
      wr(3'd3, 8'h20);
      peek(3'd3, d);
      chk("R7 combined mask readback", d, 8'h20);
      chk("R10 channel B rx", {5'b0, irq_any, irq_chan}, 8'h06);
      peek(3'd7, d);
      chk("R9 channel B mask view", d, 8'h02);
      wr(3'd5, 8'hF1);
      peek(3'd3, d);
      chk("R9 channel A write aliases", d, 8'h21);
      chk("R10 both lines", {5'b0, irq_any, irq_chan}, 8'h07);
      wr(3'd7, 8'h00);
      peek(3'd3, d);
      chk("R9 channel B cleared", d, 8'h01);
      chk("R10 only A", {5'b0, irq_any, irq_chan}, 8'h05);
      uart_brk_req = 2'b10;
      wr(3'd3, 8'h80);
      chk("R10 input source B", {5'b0, irq_any, irq_chan}, 8'h06);
      wr(3'd1, 8'h07);
      peek(3'd2, d);
      chk("R6 disabled pin hides input", d, 8'h61);
      chk("R10 input masked by enable", {5'b0, irq_any, irq_chan}, 8'h00);
      wr(3'd1, 8'h0F);
      chk("R10 input back", {5'b0, irq_any, irq_chan}, 8'h06);
   endtask

   task automatic t_ro;
      wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
      peek(3'd3, d);
      chk("R11 mask untouched", d, 8'h80);
      peek(3'd1, d);
      chk("R11 aux untouched", d, 8'h0F);
      peek(3'd0, d);
      chk("R11 change reg untouched", d, 8'h88);
      peek(3'd2, d);
      chk("R11 status untouched", d, 8'hE1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aux();
      t_live();
      t_flag();
      t_race();
      t_merge();
      t_ro();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule